// File: doc/BRIEF.md
# SDRAM Command Monitor and Legality Checker

This block sits beside the command pins of a four-bank synchronous DRAM. On every rising clock edge it samples the clock-enable, chip-select, row strobe, column strobe and write-enable lines together with the bank select and the auto-precharge address bit. From these it forms a named command code. It keeps a timed state for each bank (idle, open, write recovering) and one for the whole device (refreshing). Every command is judged against that state. A command that the current state forbids raises a one-cycle flag that carries the offending code, and such a command leaves all state untouched.

The burst length, the write-recovery time and the refresh cycle time arrive as cycle counts on input ports. One monitor can therefore follow any speed grade without being rebuilt. The typical use is as a protocol guard in a memory-controller subsystem or an emulation harness. There its flag is routed to an error counter or a trigger.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: When `clk_en` is low or `chip_sel_n` is high at a rising edge, the cycle is decoded as deselect, code 0. `cmd_o` shows the code of each sampled cycle starting on the edge that samples it.
- R2: With `chip_sel_n` low and `clk_en` high, the strobes {row,col,wr} decode as follows: 111 = NOP (1), 110 = burst stop (2), 101 = read (3, or 9 with `auto_pre`), 100 = write (4, or 10 with `auto_pre`), 011 = activate (5), 010 = precharge (6, or 11 for all banks with `auto_pre`), 001 = refresh (7), 000 = mode set (8).
- R3: Activate opens an idle bank, so its field in `bank_state_o` (bits 2b+1:2b, 0 idle, 1 open, 2 write recovering, 3 refreshing) becomes 1. Activate to a bank that is not idle is illegal.
- R4: Read or write to a bank that is not open is illegal. Read or write to an open bank is legal.
- R5: A legal write puts its bank in state 2 for exactly `burst_len + t_wr` sampled cycles, starting on the edge of the write. The bank then returns to open, or to idle when `auto_pre` was high on the write.
- R6: While any bank recovers, burst stop, refresh, mode set and precharge-all are illegal, and so is every read, write, activate or precharge to the recovering bank. The same commands to other banks are judged by their own state.
- R7: A read with `auto_pre` keeps its bank open for `burst_len` sampled cycles and then idles it. In that window a read, write or activate to that bank is illegal, while a precharge to it is legal and idles it at once.
- R8: Precharge with `auto_pre` low closes only the selected bank, and precharge to an idle bank is legal and changes nothing. Precharge with `auto_pre` high closes every bank.
- R9: Refresh is legal only when all banks are idle. It then shows state 3 on every bank for `t_rc` sampled cycles, after which all banks are idle.
- R10: While refreshing, every command other than deselect and NOP is illegal, including one issued on the last refresh cycle.
- R11: `illegal_o` is a registered one-cycle pulse per illegal command, with `illegal_cmd_o` equal to the offending code; otherwise `illegal_cmd_o` is 0. An illegal command changes no bank or refresh state.
- R12: A synchronous active-high `rst` makes all banks idle, ends any refresh and clears `cmd_o`, `illegal_o` and `illegal_cmd_o`.
- R13: Burst stop is legal, and changes nothing, when no bank recovers and no refresh runs. Mode set is legal only when every bank is idle and no refresh runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, commands sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock-enable line of the memory |
| chip_sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | Row address strobe, active low |
| col_strobe_n | input | 1 | Column address strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| bank_sel | input | BAW | Bank select |
| auto_pre | input | 1 | Auto-precharge / all-bank qualifier |
| burst_len | input | CW | Burst length in cycles (at least 1) |
| t_wr | input | CW | Write-recovery cycles after the last write data |
| t_rc | input | CW | Refresh cycle time in cycles (at least 1) |
| cmd_o | output | 4 | Registered decoded command code |
| bank_state_o | output | 2*NB | Two-bit state per bank |
| illegal_o | output | 1 | One-cycle illegal-command pulse |
| illegal_cmd_o | output | 4 | Code of the illegal command, 0 otherwise |

## Verification
On every cycle, the embedded assertions check the following. The illegal flag and its code agree. No refresh starts unless every bank is idle. Any non-NOP command during a refresh, and any access to a recovering bank, is flagged. Timers hold their state until they expire, and an idle bank never jumps straight into recovery. The exact window lengths need the bench's scenarios: the recovery time swept over several values, the auto-precharge read, and the refresh that ends on the cycle of a rejected command. The same holds for the decode of every pin pattern from idle and for the rule that rejected commands leave other banks unchanged.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [3:0] {
    C_DESEL = 4'd0,
    C_NOP   = 4'd1,
    C_STOP  = 4'd2,
    C_RD    = 4'd3,
    C_WR    = 4'd4,
    C_ACT   = 4'd5,
    C_PRE   = 4'd6,
    C_REF   = 4'd7,
    C_MRS   = 4'd8,
    C_RDA   = 4'd9,
    C_WRA   = 4'd10,
    C_PREA  = 4'd11
  } cmd_e;

  typedef enum logic [1:0] {
    B_IDLE = 2'd0,
    B_OPEN = 2'd1,
    B_WREC = 2'd2,
    B_RFSH = 2'd3
  } bst_e;

endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic clk_en,
  input  logic chip_sel_n,
  input  logic row_strobe_n,
  input  logic col_strobe_n,
  input  logic wr_en_n,
  input  logic auto_pre,
  output cmd_e code
);

  always_comb begin
    code = C_DESEL;
    if (clk_en && !chip_sel_n) begin
      case ({row_strobe_n, col_strobe_n, wr_en_n})
        3'b111:  code = C_NOP;
        3'b110:  code = C_STOP;
        3'b101:  code = auto_pre ? C_RDA : C_RD;
        3'b100:  code = auto_pre ? C_WRA : C_WR;
        3'b011:  code = C_ACT;
        3'b010:  code = auto_pre ? C_PREA : C_PRE;
        3'b001:  code = C_REF;
        default: code = C_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdc_bank.sv
module sdc_bank
  import sdc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  cmd_e          cmd,
  input  logic [CW-1:0] burst_len,
  input  logic [CW-1:0] t_wr,
  output bst_e          st,
  output logic          ap
);

  localparam logic [CW:0] ONE = (CW+1)'(1);

  logic [CW:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= B_IDLE;
      ap  <= 1'b0;
      cnt <= '0;
    end else if (hit) begin
      case (cmd)
        C_ACT: st <= B_OPEN;
        C_RDA: begin
          ap  <= 1'b1;
          cnt <= {1'b0, burst_len} - ONE;
        end
        C_WR, C_WRA: begin
          st  <= B_WREC;
          ap  <= (cmd == C_WRA);
          cnt <= {1'b0, burst_len} + {1'b0, t_wr} - ONE;
        end
        C_PRE, C_PREA: begin
          st <= B_IDLE;
          ap <= 1'b0;
        end
        default: ;
      endcase
    end else if (st == B_WREC) begin
      if (cnt == '0) begin
        st <= ap ? B_IDLE : B_OPEN;
        ap <= 1'b0;
      end else begin
        cnt <= cnt - ONE;
      end
    end else if (st == B_OPEN && ap) begin
      if (cnt == '0) begin
        st <= B_IDLE;
        ap <= 1'b0;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  // An idle bank must be opened before any write can start recovery
  assert_idle_not_to_wrec_R5: assert property (@(posedge clk) disable iff (rst)
    (st == B_IDLE) |=> (st != B_WREC));

  // A pending auto-precharge only exists on a bank that is in use
  assert_ap_needs_open_R7: assert property (@(posedge clk) disable iff (rst)
    ap |-> (st != B_IDLE));

  // Recovery cannot be cut short while its timer still runs
  assert_wrec_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (st == B_WREC && cnt != '0) |=> (st == B_WREC));

endmodule

// File: rtl/sdc_refresh.sv
module sdc_refresh #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] t_rc,
  output logic          busy
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= t_rc - CW'(1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assert_refresh_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdc_pkg::*;
#(
  parameter int NB  = 4,
  parameter int CW  = 8,
  localparam int BAW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clk_en,
  input  logic            chip_sel_n,
  input  logic            row_strobe_n,
  input  logic            col_strobe_n,
  input  logic            wr_en_n,
  input  logic [BAW-1:0]  bank_sel,
  input  logic            auto_pre,
  input  logic [CW-1:0]   burst_len,
  input  logic [CW-1:0]   t_wr,
  input  logic [CW-1:0]   t_rc,
  output logic [3:0]      cmd_o,
  output logic [2*NB-1:0] bank_state_o,
  output logic            illegal_o,
  output logic [3:0]      illegal_cmd_o
);

  cmd_e          cmd;
  bst_e          bst  [NB];
  logic [NB-1:0] ap_v;
  logic [NB-1:0] is_idle;
  logic [NB-1:0] is_wrec;
  logic [NB-1:0] hit;
  logic          rf_busy;
  logic          legal;
  logic          any_wrec;
  logic          all_idle;
  bst_e          tgt_st;
  logic          tgt_ap;
  logic          targets_bank;

  sdc_decode u_dec (
    .clk_en       (clk_en),
    .chip_sel_n   (chip_sel_n),
    .row_strobe_n (row_strobe_n),
    .col_strobe_n (col_strobe_n),
    .wr_en_n      (wr_en_n),
    .auto_pre     (auto_pre),
    .code         (cmd)
  );

  assign targets_bank = (cmd == C_ACT) || (cmd == C_RD) || (cmd == C_RDA) ||
                        (cmd == C_WR)  || (cmd == C_WRA) || (cmd == C_PRE);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    assign hit[i] = legal && ((cmd == C_PREA) ||
                              (targets_bank && bank_sel == BAW'(i)));

    sdc_bank #(.CW(CW)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .hit       (hit[i]),
      .cmd       (cmd),
      .burst_len (burst_len),
      .t_wr      (t_wr),
      .st        (bst[i]),
      .ap        (ap_v[i])
    );

    assign is_idle[i] = (bst[i] == B_IDLE);
    assign is_wrec[i] = (bst[i] == B_WREC);
    assign bank_state_o[2*i +: 2] = rf_busy ? B_RFSH : bst[i];
  end

  assign any_wrec = |is_wrec;
  assign all_idle = &is_idle;
  assign tgt_st   = bst[bank_sel];
  assign tgt_ap   = ap_v[bank_sel];

  sdc_refresh #(.CW(CW)) u_rfsh (
    .clk   (clk),
    .rst   (rst),
    .start (legal && cmd == C_REF),
    .t_rc  (t_rc),
    .busy  (rf_busy)
  );

  always_comb begin
    case (cmd)
      C_DESEL, C_NOP:        legal = 1'b1;
      C_STOP, C_PREA:        legal = !rf_busy && !any_wrec;
      C_RD, C_RDA,
      C_WR, C_WRA:           legal = !rf_busy && tgt_st == B_OPEN && !tgt_ap;
      C_ACT:                 legal = !rf_busy && tgt_st == B_IDLE;
      C_PRE:                 legal = !rf_busy && tgt_st != B_WREC;
      C_REF, C_MRS:          legal = !rf_busy && all_idle;
      default:               legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o         <= C_DESEL;
      illegal_o     <= 1'b0;
      illegal_cmd_o <= C_DESEL;
    end else begin
      cmd_o         <= cmd;
      illegal_o     <= !legal;
      illegal_cmd_o <= legal ? C_DESEL : cmd;
    end
  end

  assert_pulse_carries_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (illegal_cmd_o == cmd_o && cmd_o != C_DESEL && cmd_o != C_NOP));

  assert_quiet_when_legal_R11: assert property (@(posedge clk) disable iff (rst)
    !illegal_o |-> (illegal_cmd_o == C_DESEL));

  assert_refresh_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (rf_busy && cmd != C_DESEL && cmd != C_NOP) |=> illegal_o);

  assert_refresh_from_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(rf_busy) |-> $past(all_idle));

  assert_wrec_target_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    (tgt_st == B_WREC && targets_bank) |=> illegal_o);

endmodule

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;

  localparam int NB = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          clk_en = 1'b1, chip_sel_n = 1'b1;
  logic          row_strobe_n = 1'b1, col_strobe_n = 1'b1, wr_en_n = 1'b1;
  logic [1:0]    bank_sel = '0;
  logic          auto_pre = 1'b0;
  logic [CW-1:0] burst_len = 8'd2, t_wr = 8'd2, t_rc = 8'd3;
  logic [3:0]    cmd_o, illegal_cmd_o;
  logic [7:0]    bank_state_o;
  logic          illegal_o;

  int  total = 0, bad = 0;
  bit  finished = 1'b0;

  sdram_cmd_monitor #(.NB(NB), .CW(CW)) dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .chip_sel_n(chip_sel_n),
    .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n),
    .bank_sel(bank_sel), .auto_pre(auto_pre), .burst_len(burst_len),
    .t_wr(t_wr), .t_rc(t_rc), .cmd_o(cmd_o), .bank_state_o(bank_state_o),
    .illegal_o(illegal_o), .illegal_cmd_o(illegal_cmd_o)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic drv(bit ce, bit cs, bit r, bit c, bit w, int b, bit a);
    @(negedge clk);
    clk_en = ce; chip_sel_n = cs; row_strobe_n = r; col_strobe_n = c;
    wr_en_n = w; bank_sel = 2'(b); auto_pre = a;
    @(posedge clk);
    #1;
  endtask

  // p = {row,col,wr} strobes: 7 NOP, 6 stop, 5 read, 4 write, 3 act, 2 pre, 1 ref, 0 mode
  task automatic cmd(int p, int b, bit a);
    drv(1'b1, 1'b0, p[2], p[1], p[0], b, a);
  endtask

  task automatic idle_cyc();
    drv(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; chip_sel_n = 1'b1; clk_en = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int st(int b);
    return int'(bank_state_o[2*b +: 2]);
  endfunction

  function automatic int ecode(int p, bit a);
    case (p)
      7: return 1;
      6: return 2;
      5: return a ? 9 : 3;
      4: return a ? 10 : 4;
      3: return 5;
      2: return a ? 11 : 6;
      1: return 7;
      default: return 8;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    do_reset();
    #1;
    chk("R12 bank states", bank_state_o, 0);
    chk("R12 cmd", cmd_o, 0);
    chk("R12 illegal", illegal_o, 0);
    chk("R12 illegal code", illegal_cmd_o, 0);

    // R1: deselect and clock-enable low decode to 0
    drv(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    chk("R1 deselect", cmd_o, 0);
    drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b0);
    chk("R1 cke low", cmd_o, 0);
    chk("R1 cke low no refresh", bank_state_o, 0);

    // R2/R4/R13: every pin pattern from the all-idle state
    for (int p = 0; p < 8; p++) begin
      for (int a = 0; a < 2; a++) begin
        do_reset();
        cmd(p, p % 4, a[0]);
        chk("R2 decode", cmd_o, ecode(p, a[0]));
        chk("R4 R13 legality from idle", illegal_o, (p == 5 || p == 4) ? 1 : 0);
        if (p == 3) chk("R3 open", st(p % 4), 1);
        if (p == 1) chk("R9 refresh all", bank_state_o, 8'hFF);
        if (p == 2) chk("R8 pre idle no change", bank_state_o, 0);
      end
    end

    // R3/R11: double activate
    do_reset();
    cmd(3, 1, 0);
    chk("R3 open b1", st(1), 1);
    cmd(3, 1, 0);
    chk("R3 double act illegal", illegal_o, 1);
    chk("R11 offending code", illegal_cmd_o, 5);
    chk("R11 state kept", st(1), 1);
    idle_cyc();
    chk("R11 pulse width", illegal_o, 0);
    cmd(5, 1, 0);
    chk("R4 read open legal", illegal_o, 0);
    cmd(4, 2, 0);
    chk("R4 write idle illegal", illegal_o, 1);
    chk("R11 write code", illegal_cmd_o, 4);
    // R13: burst stop legal with open bank, mode set not
    cmd(6, 0, 0);
    chk("R13 stop legal", illegal_o, 0);
    chk("R13 stop no change", bank_state_o, 8'h04);
    cmd(0, 0, 0);
    chk("R13 mode set with open bank", illegal_o, 1);

    // R5: recovery window length swept over t_wr
    for (int tw = 1; tw <= 4; tw++) begin
      int n;
      t_wr = 8'(tw);
      do_reset();
      cmd(3, 1, 0);
      cmd(4, 1, 0);
      n = 0;
      while (st(1) == 2 && n < 50) begin
        n++;
        idle_cyc();
      end
      chk("R5 window", n, 2 + tw);
      chk("R5 back to open", st(1), 1);
    end

    // R6: commands during recovery (burst 2 + t_wr 5 = 7 cycles)
    t_wr = 8'd5;
    do_reset();
    cmd(3, 0, 0);
    cmd(3, 1, 0);
    cmd(4, 1, 0);
    cmd(5, 1, 0); chk("R6 read recovering bank", illegal_o, 1);
    cmd(5, 0, 0); chk("R6 read other bank", illegal_o, 0);
    cmd(6, 0, 0); chk("R6 stop", illegal_o, 1);
    cmd(1, 0, 0); chk("R6 refresh", illegal_o, 1);
    cmd(2, 0, 1); chk("R6 precharge all", illegal_o, 1);
    cmd(0, 0, 0); chk("R6 mode set", illegal_o, 1);
    cmd(2, 1, 0); chk("R6 precharge recovering bank", illegal_o, 1);
    chk("R6 recovery over", st(1), 1);
    chk("R11 other bank kept", st(0), 1);
    cmd(5, 1, 0); chk("R6 read after recovery", illegal_o, 0);

    // R5: write with auto-precharge ends idle
    t_wr = 8'd2;
    do_reset();
    cmd(3, 2, 0);
    cmd(4, 2, 1);
    repeat (3) idle_cyc();
    chk("R5 still recovering", st(2), 2);
    idle_cyc();
    chk("R5 auto precharge idle", st(2), 0);

    // R7: read with auto-precharge
    do_reset();
    cmd(3, 3, 0);
    cmd(5, 3, 1);
    chk("R7 read ap legal", illegal_o, 0);
    cmd(5, 3, 0);
    chk("R7 read during ap", illegal_o, 1);
    chk("R7 still open", st(3), 1);
    idle_cyc();
    chk("R7 closed", st(3), 0);
    cmd(3, 3, 0);
    cmd(5, 3, 1);
    cmd(2, 3, 0);
    chk("R7 precharge during ap", illegal_o, 0);
    chk("R7 precharge closes", st(3), 0);

    // R8: single and all-bank precharge
    do_reset();
    cmd(3, 0, 0);
    cmd(3, 1, 0);
    cmd(2, 0, 0);
    chk("R8 single close", bank_state_o, 8'h04);
    cmd(2, 0, 0);
    chk("R8 pre idle legal", illegal_o, 0);
    chk("R8 pre idle no change", bank_state_o, 8'h04);
    cmd(2, 2, 1);
    chk("R8 all close", bank_state_o, 0);

    // R9/R10: refresh window, t_rc = 3
    do_reset();
    cmd(1, 0, 0);
    chk("R9 refreshing", bank_state_o, 8'hFF);
    cmd(3, 0, 0); chk("R10 act refreshing", illegal_o, 1);
    cmd(7, 0, 0); chk("R10 nop refreshing", illegal_o, 0);
    cmd(6, 0, 0); chk("R10 stop on last cycle", illegal_o, 1);
    chk("R9 refresh over", bank_state_o, 0);
    cmd(3, 0, 0); chk("R9 act after refresh", illegal_o, 0);
    cmd(1, 0, 0);
    chk("R9 refresh with open bank", illegal_o, 1);
    chk("R11 refresh rejected no change", bank_state_o, 8'h01);

    // R12: reset mid operation
    cmd(3, 2, 0);
    do_reset();
    #1;
    chk("R12 mid reset", bank_state_o, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule